// File: doc/BRIEF.md
# Power-Mode Control Register

This block holds one 32-bit control word for a power-management unit. A register bus writes and reads it by word address, with byte-lane strobes. A half-word write and a full-word write are both supported. The block sets low-driver, high-driver and regulator-voltage fields, and it also accepts two write-one command bits that clear status flags held elsewhere.

Some bits do not simply store what software writes. The high-driver enable and high-driver switch bits accept a 1 only when side conditions hold. These conditions are the selected system clock source and a driver-ready flag. The same two bits are cleared by hardware when deep-sleep ends. The regulator-voltage field can only be written while the main PLL is stopped. It is stored at all times, but it drives the applied voltage mode only while the PLL runs. A standby-wakeup input reloads the whole word to its reset value, just as power-up does.

Top module: `pwr_mode_reg`

## Requirements
- R1: After rst_n is asserted, and in the cycle after sbyWake is high, the word reads 0x0000C000. sbyWake takes priority over a write in the same cycle.
- R2: wrStrb[2] gates bits 19:16, wrStrb[1] gates bits 15:14 and wrStrb[0] gates bits 3:2. A field whose lane strobe is low keeps its value.
- R3: Bits 19:18 (lowDrvField) store any value written. lowDrvEn is 1 only when the field is 11.
- R4: Bit 16 (hiDrvEn) becomes 1 on a write of 1 only when clkSrc is 00 (internal RC) or 01 (crystal). Under any other clock source the write of 1 is ignored. A write of 0 always clears the bit.
- R5: Bit 17 (hiDrvSw) becomes 1 on a write of 1 only when hdReady is 1, clkSrc is 00 or 01, and bit 16 is 1 after the same write. Otherwise the write of 1 is ignored. A write of 0 clears the bit.
- R6: A cycle with dsExit high clears bits 16 and 17.
- R7: bit 17 is 0 whenever bit 16 is 0. A write of 0 to bit 16 and 1 to bit 17 in the same cycle leaves both bits at 0.
- R8: Bits 15:14 (ldoSel) take a write only when pllOn is 0. While pllOn is 1, writes to them are ignored.
- R9: ldoApplied equals ldoSel while pllOn is 1, and is 00 (the low-voltage mode) while pllOn is 0.
- R10: Bits 31:20, 13:4 and 1:0 read as 0 and ignore writes. A write to any address other than REG_ADDR changes nothing, and a read of such an address returns 0.
- R11: A write of 1 to bit 3 gives a one-cycle clrStbyFlag pulse, and a write of 1 to bit 2 gives a one-cycle clrWakeFlag pulse. Each pulse appears in the cycle after the write. Both bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| addr | input | ADDR_W | Word address |
| wrEn | input | 1 | Write enable |
| wrData | input | 32 | Write data |
| wrStrb | input | 4 | Byte-lane strobes |
| rdData | output | 32 | Read data for addr |
| clkSrc | input | 2 | System clock source: 00 internal RC, 01 crystal, 10 PLL, 11 other |
| hdReady | input | 1 | High-driver ready flag |
| pllOn | input | 1 | Main PLL enabled |
| dsExit | input | 1 | Deep-sleep exit pulse |
| sbyWake | input | 1 | Synchronous reload on standby wakeup |
| lowDrvField | output | 2 | Stored low-driver field |
| lowDrvEn | output | 1 | Low-driver deep-sleep enabled |
| hiDrvEn | output | 1 | High-driver enable bit |
| hiDrvSw | output | 1 | High-driver switch bit |
| ldoSel | output | 2 | Stored regulator voltage select |
| ldoApplied | output | 2 | Regulator voltage mode in effect |
| clrStbyFlag | output | 1 | Standby-flag clear pulse |
| clrWakeFlag | output | 1 | Wakeup-flag clear pulse |

## Verification
The high-driver bits are written under every mix of qualifying and non-qualifying clock source and ready flag. This separates a write that is ignored from one that takes effect, and it includes the conflicting case where the enable is cleared while the switch is set in the same write. The voltage field is written with the PLL stopped and with it running, to tell the stored value apart from the applied one. Writes with only the upper strobes or only the lower strobes, writes to a wrong address and all-ones writes to reserved bits show which lanes and bits respond. Deep-sleep exit and standby wakeup are each raised over a non-reset state, the wakeup together with a competing write.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  localparam int DATA_W = 32;
  localparam int STRB_W = DATA_W / 8;
  localparam logic [DATA_W-1:0] RESET_WORD = 32'h0000_C000;

  localparam int LOWDRV_LSB = 18;
  localparam int HDSW_BIT   = 17;
  localparam int HDEN_BIT   = 16;
  localparam int LDO_LSB    = 14;
  localparam int CSTBY_BIT  = 3;
  localparam int CWAKE_BIT  = 2;

  typedef enum logic [1:0] {
    CLK_IRC   = 2'b00,
    CLK_XTAL  = 2'b01,
    CLK_PLL   = 2'b10,
    CLK_OTHER = 2'b11
  } clkSrc_e;

  localparam logic [1:0] LDO_LOW = 2'b00;

  typedef struct packed {
    logic       reload;
    logic       lowDrvWr;
    logic [1:0] lowDrvVal;
    logic       hdEnNext;
    logic       hdSwNext;
    logic       ldoWr;
    logic [1:0] ldoVal;
    logic       pulseStby;
    logic       pulseWake;
    logic       rdHit;
  } ctlStrobes_t;
endpackage

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int REG_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic [STRB_W-1:0] wrStrb,
  input  logic [1:0]        clkSrc,
  input  logic              hdReady,
  input  logic              pllOn,
  input  logic              dsExit,
  input  logic              sbyWake,
  input  logic              curHdEn,
  input  logic              curHdSw,
  output ctlStrobes_t       st
);
  logic hit, lane0, lane1, lane2, clkOk;
  logic unusedWr;

  assign hit   = (addr == ADDR_W'(REG_ADDR));
  assign lane0 = wrEn && hit && wrStrb[0];
  assign lane1 = wrEn && hit && wrStrb[1];
  assign lane2 = wrEn && hit && wrStrb[2];
  assign clkOk = (clkSrc == CLK_IRC) || (clkSrc == CLK_XTAL);
  assign unusedWr = ^{wrData[31:20], wrData[13:4], wrData[1:0], wrStrb[3], clk, rst_n};

  always_comb begin
    st = '0;
    st.reload    = sbyWake;
    st.rdHit     = hit;
    st.lowDrvWr  = lane2;
    st.lowDrvVal = wrData[LOWDRV_LSB +: 2];
    st.ldoWr     = lane1 && !pllOn;
    st.ldoVal    = wrData[LDO_LSB +: 2];
    st.pulseStby = lane0 && wrData[CSTBY_BIT];
    st.pulseWake = lane0 && wrData[CWAKE_BIT];

    // enable bit: hardware exit clear beats software
    if (dsExit)                                st.hdEnNext = 1'b0;
    else if (lane2 && !wrData[HDEN_BIT])       st.hdEnNext = 1'b0;
    else if (lane2 && wrData[HDEN_BIT] && clkOk) st.hdEnNext = 1'b1;
    else                                       st.hdEnNext = curHdEn;

    // switch bit follows the enable down
    if (!st.hdEnNext)                          st.hdSwNext = 1'b0;
    else if (lane2 && !wrData[HDSW_BIT])       st.hdSwNext = 1'b0;
    else if (lane2 && wrData[HDSW_BIT] && hdReady && clkOk) st.hdSwNext = 1'b1;
    else                                       st.hdSwNext = curHdSw;
  end
endmodule

// File: rtl/pwr_mode_dp.sv
module pwr_mode_dp
  import pwr_mode_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pllOn,
  input  ctlStrobes_t       st,
  output logic [DATA_W-1:0] rdData,
  output logic [1:0]        lowDrvField,
  output logic              hiDrvEn,
  output logic              hiDrvSw,
  output logic [1:0]        ldoSel,
  output logic [1:0]        ldoApplied,
  output logic              clrStbyFlag,
  output logic              clrWakeFlag
);
  logic [DATA_W-1:0] word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lowDrvField <= RESET_WORD[LOWDRV_LSB +: 2];
      hiDrvEn     <= RESET_WORD[HDEN_BIT];
      hiDrvSw     <= RESET_WORD[HDSW_BIT];
      ldoSel      <= RESET_WORD[LDO_LSB +: 2];
      clrStbyFlag <= 1'b0;
      clrWakeFlag <= 1'b0;
    end else if (st.reload) begin
      lowDrvField <= RESET_WORD[LOWDRV_LSB +: 2];
      hiDrvEn     <= RESET_WORD[HDEN_BIT];
      hiDrvSw     <= RESET_WORD[HDSW_BIT];
      ldoSel      <= RESET_WORD[LDO_LSB +: 2];
      clrStbyFlag <= 1'b0;
      clrWakeFlag <= 1'b0;
    end else begin
      if (st.lowDrvWr) lowDrvField <= st.lowDrvVal;
      if (st.ldoWr)    ldoSel      <= st.ldoVal;
      hiDrvEn     <= st.hdEnNext;
      hiDrvSw     <= st.hdSwNext;
      clrStbyFlag <= st.pulseStby;
      clrWakeFlag <= st.pulseWake;
    end
  end

  always_comb begin
    word = '0;
    word[LOWDRV_LSB +: 2] = lowDrvField;
    word[HDSW_BIT]        = hiDrvSw;
    word[HDEN_BIT]        = hiDrvEn;
    word[LDO_LSB +: 2]    = ldoSel;
  end

  assign rdData     = st.rdHit ? word : '0;
  assign ldoApplied = pllOn ? ldoSel : LDO_LOW;

  assert_sw_needs_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hiDrvSw |-> hiDrvEn);
  assert_ldo_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pllOn && !st.reload) |=> $stable(ldoSel));
  assert_dsexit_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    st.hdEnNext == 1'b0 |=> (!hiDrvEn && !hiDrvSw));
endmodule

// File: rtl/pwr_mode_reg.sv
module pwr_mode_reg
  import pwr_mode_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int REG_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [31:0]       wrData,
  input  logic [3:0]        wrStrb,
  output logic [31:0]       rdData,
  input  logic [1:0]        clkSrc,
  input  logic              hdReady,
  input  logic              pllOn,
  input  logic              dsExit,
  input  logic              sbyWake,
  output logic [1:0]        lowDrvField,
  output logic              lowDrvEn,
  output logic              hiDrvEn,
  output logic              hiDrvSw,
  output logic [1:0]        ldoSel,
  output logic [1:0]        ldoApplied,
  output logic              clrStbyFlag,
  output logic              clrWakeFlag
);
  ctlStrobes_t st;

  pwr_mode_ctrl #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .wrStrb(wrStrb), .clkSrc(clkSrc), .hdReady(hdReady), .pllOn(pllOn),
    .dsExit(dsExit), .sbyWake(sbyWake), .curHdEn(hiDrvEn), .curHdSw(hiDrvSw),
    .st(st)
  );

  pwr_mode_dp u_dp (
    .clk(clk), .rst_n(rst_n), .pllOn(pllOn), .st(st), .rdData(rdData),
    .lowDrvField(lowDrvField), .hiDrvEn(hiDrvEn), .hiDrvSw(hiDrvSw),
    .ldoSel(ldoSel), .ldoApplied(ldoApplied),
    .clrStbyFlag(clrStbyFlag), .clrWakeFlag(clrWakeFlag)
  );

  assign lowDrvEn = (lowDrvField == 2'b11);

  assert_sw_qualified_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hiDrvSw) |-> ($past(hdReady) &&
      ($past(clkSrc) == CLK_IRC || $past(clkSrc) == CLK_XTAL)));
  assert_wake_reload_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sbyWake |=> (ldoSel == 2'b11 && !hiDrvEn && !hiDrvSw && lowDrvField == 2'b00));
  assert_cmd_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    clrStbyFlag |-> $past(wrEn && wrStrb[0] && wrData[3] && addr == ADDR_W'(REG_ADDR)));
endmodule

// File: tb/sim_pwr_mode_reg.sv
module sim_pwr_mode_reg;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] addr = '0;
  logic wrEn = 1'b0;
  logic [31:0] wrData = '0, rdData;
  logic [3:0] wrStrb = '0;
  logic [1:0] clkSrc = 2'b10;
  logic hdReady = 1'b0, pllOn = 1'b0, dsExit = 1'b0, sbyWake = 1'b0;
  logic [1:0] lowDrvField, ldoSel, ldoApplied;
  logic lowDrvEn, hiDrvEn, hiDrvSw, clrStbyFlag, clrWakeFlag;
  int nChecks = 0, nFails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pwr_mode_reg u0 (.*);

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d, input logic [3:0] s, input logic [3:0] a = 4'd0);
    @(negedge clk);
    addr = a; wrData = d; wrStrb = s; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; addr = 4'd0; wrStrb = '0; wrData = '0;
    #1;
  endtask

  task automatic t_reset();
    check("R1 reset word", rdData, 32'h0000C000);
    check("R3 lowDrvEn reset", {31'd0, lowDrvEn}, 0);
    check("R9 applied low when pll off", {30'd0, ldoApplied}, 0);
  endtask

  task automatic t_lowdrv();
    wr(32'h000C0000, 4'b0100);
    check("R3 field 11", rdData, 32'h000CC000);
    check("R3 lowDrvEn on 11", {31'd0, lowDrvEn}, 1);
    wr(32'h00080000, 4'b0100);
    check("R3 field 10 stored", rdData, 32'h0008C000);
    check("R3 lowDrvEn off on 10", {31'd0, lowDrvEn}, 0);
    wr(32'h0, 4'b0100);
  endtask

  task automatic t_hden();
    clkSrc = 2'b10;
    wr(32'h00010000, 4'b0100);
    check("R4 enable ignored on PLL clock", {31'd0, hiDrvEn}, 0);
    clkSrc = 2'b00;
    wr(32'h00010000, 4'b0100);
    check("R4 enable set on RC clock", {31'd0, hiDrvEn}, 1);
    wr(32'h0, 4'b0100);
    check("R4 enable cleared by 0", {31'd0, hiDrvEn}, 0);
  endtask

  task automatic t_hdsw();
    clkSrc = 2'b01; hdReady = 1'b0;
    wr(32'h00030000, 4'b0100);
    check("R5 switch ignored without ready", rdData, 32'h0001C000);
    hdReady = 1'b1;
    wr(32'h00030000, 4'b0100);
    check("R5 switch set when qualified", rdData, 32'h0003C000);
    wr(32'h00020000, 4'b0100);
    check("R7 clear of enable wins over switch", rdData, 32'h0000C000);
  endtask

  task automatic t_dsexit();
    wr(32'h00030000, 4'b0100);
    check("R6 precondition both set", rdData, 32'h0003C000);
    @(negedge clk); dsExit = 1'b1;
    @(negedge clk); dsExit = 1'b0; #1;
    check("R6 deep-sleep exit clears", rdData, 32'h0000C000);
    hdReady = 1'b0; clkSrc = 2'b10;
  endtask

  task automatic t_ldo();
    wr(32'h00004000, 4'b0010);
    check("R8 write with pll off", {30'd0, ldoSel}, 1);
    check("R9 applied low while pll off", {30'd0, ldoApplied}, 0);
    pllOn = 1'b1; #1;
    check("R9 applied follows field", {30'd0, ldoApplied}, 1);
    wr(32'h0000C000, 4'b0010);
    check("R8 write ignored with pll on", {30'd0, ldoSel}, 1);
    pllOn = 1'b0;
    wr(32'h0000C000, 4'b0010);
  endtask

  task automatic t_lanes();
    wr(32'h000C0000, 4'b1100);
    check("R2 upper-half write keeps ldo", rdData, 32'h000CC000);
    wr(32'hFFFF0000, 4'b0011);
    check("R2 lower-half write keeps upper", rdData, 32'h000C0000);
  endtask

  task automatic t_reserved();
    wr(32'h0000C000, 4'b1111, 4'd1);
    check("R10 other address ignored", rdData, 32'h000C0000);
    @(negedge clk); addr = 4'd1; #1;
    check("R10 other address reads 0", rdData, 0);
    addr = 4'd0;
    wr(32'hFFF03FF3, 4'b1111);
    check("R10 reserved bits read 0", rdData, 32'h0);
  endtask

  task automatic t_cmd();
    wr(32'h00000008, 4'b0001);
    check("R11 standby clear pulse", {30'd0, clrStbyFlag, clrWakeFlag}, 2);
    check("R11 command bits read 0", rdData, 0);
    @(negedge clk); #1;
    check("R11 pulse one cycle", {30'd0, clrStbyFlag, clrWakeFlag}, 0);
    wr(32'h00000004, 4'b0001);
    check("R11 wake clear pulse", {30'd0, clrStbyFlag, clrWakeFlag}, 1);
  endtask

  task automatic t_wake();
    wr(32'h000C0000, 4'b0100);
    @(negedge clk);
    sbyWake = 1'b1; wrEn = 1'b1; wrData = 32'h000C0000; wrStrb = 4'b0100;
    @(negedge clk);
    sbyWake = 1'b0; wrEn = 1'b0; wrStrb = '0; wrData = '0; #1;
    check("R1 standby wakeup reloads", rdData, 32'h0000C000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1; #1;
    t_reset();
    t_lowdrv();
    t_hden();
    t_hdsw();
    t_dsexit();
    t_ldo();
    t_lanes();
    t_reserved();
    t_cmd();
    t_wake();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        nChecks++; nFails++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule